// File: doc/BRIEF.md
# Multi-channel rising-edge counter bank

This block holds a bank of independent counters, four by default and 32 bits wide. Each counts rising edges on its own asynchronous digital input. Every input is first brought into the system clock domain, and each channel sits behind a small register interface. Software writes two configuration values per channel: an enable value and a function index. The channel counts only when it is enabled, its index selects the counter function, and no other on-chip user has claimed the input.

Reads go through one request port and return on the next cycle. A read can leave the count in place, or it can return the count and clear it in the same access. A narrow read returns only the low half of the sample. The high half of that same sample goes into a shared capture register, which a later read fetches, so the two halves always come from one instant. A free-running timestamp counter advances once every two system clocks, which lets the host turn count differences into a frequency.

Top module: `edge_counter_bank`

## Requirements
- R1: An active channel adds exactly one to its count for each low-to-high transition of its input, seen after two synchronizer stages. A level held high, or a falling edge, adds nothing.
- R2: A channel is active only when three conditions hold. Its enable register holds exactly 1, written with wr_sel=0, and any other value disables it. Its index register holds 7, written with wr_sel=1. Its busy input is not blocking it. After reset the enable register is 0 and the index register is 0.
- R3: An inactive channel keeps its count unchanged and ignores its input.
- R4: A request with rd_kind=0 (live read) returns the selected channel's count on rd_data, with rd_valid high, in the cycle after the request. The count is left as it was.
- R5: A request with rd_kind=1 (read and clear) returns the count as it stood before the request, and the counter then becomes 0. If an active rising edge lands in the same cycle, the counter becomes 1 instead.
- R6: With rd_narrow=1, a kind-0 or kind-1 read returns bits NARROW_W-1:0 of the count, zero-extended, and stores the remaining upper bits of the same sample in the capture register. A kind-2 request returns the capture register, zero-extended. Wide reads and kind-2 reads leave the capture register unchanged.
- R7: chan_busy blocks channels 0, 1 and 3 while high. Channel 2 ignores its busy bit.
- R8: ts_count is 0 after reset and rises by exactly 1 every two clock cycles.
- R9: A count at its maximum value wraps to 0 on the next counted edge.
- R10: During and after reset, all counts are 0, rd_valid is 0 and the capture register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | NCH | Asynchronous edge inputs, one per channel |
| chan_busy | input | NCH | Input claimed by another user (bit 2 has no effect) |
| wr_en | input | 1 | Configuration write strobe |
| wr_chan | input | CH_W | Channel addressed by the write |
| wr_sel | input | 1 | 0 = enable register, 1 = index register |
| wr_data | input | CFG_W | Value written |
| rd_req | input | 1 | Read request |
| rd_chan | input | CH_W | Channel addressed by the read |
| rd_kind | input | 2 | 0 live, 1 read and clear, 2 capture register |
| rd_narrow | input | 1 | Return the low half only and capture the high half |
| rd_valid | output | 1 | Read data valid, one cycle after rd_req |
| rd_data | output | CW | Read result |
| ts_count | output | TS_W | Free-running timestamp |

## Verification
Short pulses separate true edge counting from level sampling, and a long held-high pulse must add one and no more. Channels are tried unconfigured, with a wrong index, disabled after counting, and blocked by their busy bit, so each gating term shows up on its own. A read-and-clear is issued in the very cycle a synchronized edge arrives, which tells a counter that drops the edge apart from one that keeps it. A narrow-width second instance shows the split read returning coherent halves and the counter wrapping after its full range.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  typedef enum logic [1:0] {
    RD_LIVE    = 2'd0,
    RD_CLEAR   = 2'd1,
    RD_CAPTURE = 2'd2,
    RD_SPARE   = 2'd3
  } rd_kind_e;

  localparam int unsigned HSC_MODE = 7;
endpackage

// File: rtl/ecb_edge_sync.sv
module ecb_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;

  // R1
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/ecb_channel.sv
module ecb_channel #(
  parameter int unsigned CW        = 32,
  parameter int unsigned CFG_W     = 8,
  parameter int unsigned MODE      = 7,
  parameter bit          SHAREABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_async,
  input  logic             busy,
  input  logic             we_enable,
  input  logic             we_index,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             clr,
  output logic [CW-1:0]    count,
  output logic             active,
  output logic             rise
);
  logic             en_q;
  logic [CFG_W-1:0] idx_q;
  logic             step;
  logic             blocked;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur,
                                               input logic step_i,
                                               input logic wipe);
    if (wipe) return step_i ? CW'(1) : '0;
    if (step_i) return cur + CW'(1);
    return cur;
  endfunction

  ecb_edge_sync u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (sig_async),
    .rise (rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      if (we_enable) en_q  <= (cfg_data == CFG_W'(1));
      if (we_index)  idx_q <= cfg_data;
    end
  end

  assign blocked = SHAREABLE && busy;
  assign active  = en_q && (idx_q == CFG_W'(MODE)) && !blocked;
  assign step    = active && rise;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= next_count(count, step, clr);
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active && rise && !clr && count != {CW{1'b1}}) |=> count == $past(count) + 1'b1);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !clr) |=> $stable(count));
  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !(active && rise)) |=> count == '0);
  // R5
  clear_keep_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && active && rise) |=> count == CW'(1));
  // R9
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (active && rise && !clr && count == {CW{1'b1}}) |=> count == '0);
endmodule

// File: rtl/ecb_timestamp.sv
module ecb_timestamp #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      ts      <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) ts <= ts + TS_W'(1);
    end
  end

  // R8
  ts_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ts) |-> ts == $past(ts) + 1'b1);
  // R8
  ts_pace_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ts) |=> $stable(ts));
endmodule

// File: rtl/edge_counter_bank.sv
module edge_counter_bank #(
  parameter int unsigned       NCH        = 4,
  parameter int unsigned       CW         = 32,
  parameter int unsigned       NARROW_W   = 16,
  parameter int unsigned       CFG_W      = 8,
  parameter int unsigned       TS_W       = 32,
  parameter int unsigned       MODE       = ecb_pkg::HSC_MODE,
  parameter logic [NCH-1:0]    SHARE_MASK = 4'b1011,
  localparam int unsigned      CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   sig_in,
  input  logic [NCH-1:0]   chan_busy,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic             wr_sel,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             rd_req,
  input  logic [CH_W-1:0]  rd_chan,
  input  logic [1:0]       rd_kind,
  input  logic             rd_narrow,
  output logic             rd_valid,
  output logic [CW-1:0]    rd_data,
  output logic [TS_W-1:0]  ts_count
);
  import ecb_pkg::*;

  localparam int unsigned CAP_W = CW - NARROW_W;

  rd_kind_e          kind;
  logic [CW-1:0]     counts [NCH];
  logic [NCH-1:0]    act_w;
  logic [NCH-1:0]    rise_w;
  logic [CW-1:0]     sel_count;
  logic [CAP_W-1:0]  cap_q;
  logic              do_capture;

  function automatic logic [CW-1:0] low_part(input logic [CW-1:0] v);
    return CW'(v[NARROW_W-1:0]);
  endfunction

  function automatic logic [CAP_W-1:0] high_part(input logic [CW-1:0] v);
    return v[CW-1:NARROW_W];
  endfunction

  assign kind = rd_kind_e'(rd_kind);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ecb_channel #(
      .CW        (CW),
      .CFG_W     (CFG_W),
      .MODE      (MODE),
      .SHAREABLE (SHARE_MASK[i])
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .sig_async (sig_in[i]),
      .busy      (chan_busy[i]),
      .we_enable (wr_en && wr_chan == CH_W'(i) && !wr_sel),
      .we_index  (wr_en && wr_chan == CH_W'(i) && wr_sel),
      .cfg_data  (wr_data),
      .clr       (rd_req && kind == RD_CLEAR && rd_chan == CH_W'(i)),
      .count     (counts[i]),
      .active    (act_w[i]),
      .rise      (rise_w[i])
    );
  end

  assign sel_count  = counts[rd_chan];
  assign do_capture = rd_req && rd_narrow && kind != RD_CAPTURE;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      cap_q    <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        if (kind == RD_CAPTURE)  rd_data <= CW'(cap_q);
        else if (rd_narrow)      rd_data <= low_part(sel_count);
        else                     rd_data <= sel_count;
      end
      if (do_capture) cap_q <= high_part(sel_count);
    end
  end

  ecb_timestamp #(.TS_W(TS_W)) u_ts (
    .clk (clk),
    .rst (rst),
    .ts  (ts_count)
  );

  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && rd_narrow && kind != RD_CAPTURE) |=> $stable(cap_q));
  // R7
  shared_free_chk: assert property (@(posedge clk) disable iff (rst)
    (SHARE_MASK[2] == 1'b0 && $changed(chan_busy[2]) && $stable(rd_req)) |-> $stable(act_w[2]) || !$stable(wr_en) || wr_en);
  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_narrow && kind != RD_CAPTURE) |=> rd_data[CW-1:NARROW_W] == '0);
endmodule

// File: tb/edge_counter_bank_test.sv
module edge_counter_bank_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0]  sig_in = '0, chan_busy = '0;
  logic        wr_en = 0, wr_sel = 0, rd_req = 0, rd_narrow = 0;
  logic [1:0]  wr_chan = 0, rd_chan = 0, rd_kind = 0;
  logic [7:0]  wr_data = 0;
  logic        rd_valid;
  logic [31:0] rd_data, ts_count;

  edge_counter_bank uut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .chan_busy(chan_busy),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_req(rd_req), .rd_chan(rd_chan), .rd_kind(rd_kind), .rd_narrow(rd_narrow),
    .rd_valid(rd_valid), .rd_data(rd_data), .ts_count(ts_count)
  );

  // narrow-width instance for split reads and wrap
  logic [3:0]  w_sig = '0;
  logic        w_wr_en = 0, w_wr_sel = 0, w_rd_req = 0, w_rd_narrow = 0;
  logic [1:0]  w_rd_kind = 0;
  logic [7:0]  w_wr_data = 0;
  logic        w_rd_valid;
  logic [7:0]  w_rd_data;
  logic [31:0] w_ts;

  edge_counter_bank #(.CW(8), .NARROW_W(4)) uut_w (
    .clk(clk), .rst(rst), .sig_in(w_sig), .chan_busy(4'b0000),
    .wr_en(w_wr_en), .wr_chan(2'd2), .wr_sel(w_wr_sel), .wr_data(w_wr_data),
    .rd_req(w_rd_req), .rd_chan(2'd2), .rd_kind(w_rd_kind), .rd_narrow(w_rd_narrow),
    .rd_valid(w_rd_valid), .rd_data(w_rd_data), .ts_count(w_ts)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  logic [31:0] m_cnt [4];
  logic [7:0]  m_en  [4];
  logic [7:0]  m_idx [4];

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R4: actual=unexpected result expected=no result");
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rd_data, it.exp, it.tag);
      end
    end
  end

  function automatic bit m_active(input int ch);
    return m_en[ch] == 8'd1 && m_idx[ch] == 8'd7 && !(ch != 2 && chan_busy[ch]);
  endfunction

  task automatic cfg(input int ch, input bit sel, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1; wr_chan = 2'(ch); wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 0;
    if (sel) m_idx[ch] = v; else m_en[ch] = v;
  endtask

  task automatic pulse(input int ch, input int hold);
    @(negedge clk);
    sig_in[ch] = 1;
    repeat (hold) @(negedge clk);
    sig_in[ch] = 0;
    repeat (3) @(negedge clk);
    if (m_active(ch)) m_cnt[ch] = m_cnt[ch] + 1;
  endtask

  task automatic rd(input int ch, input logic [1:0] kind, input bit nar,
                    input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_req = 1; rd_chan = 2'(ch); rd_kind = kind; rd_narrow = nar;
    sb.push_back('{exp, tag});
    @(negedge clk);
    rd_req = 0; rd_narrow = 0;
    @(negedge clk);
  endtask

  task automatic w_cfg(input bit sel, input logic [7:0] v);
    @(negedge clk);
    w_wr_en = 1; w_wr_sel = sel; w_wr_data = v;
    @(negedge clk);
    w_wr_en = 0;
  endtask

  task automatic w_pulse();
    @(negedge clk); w_sig[2] = 1;
    repeat (2) @(negedge clk); w_sig[2] = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic w_rd(input logic [1:0] kind, input bit nar, input logic [7:0] exp, input string tag);
    @(negedge clk);
    w_rd_req = 1; w_rd_kind = kind; w_rd_narrow = nar;
    @(negedge clk);
    w_rd_req = 0; w_rd_narrow = 0;
    check({31'b0, w_rd_valid}, 32'd1, {tag, " valid"});
    check({24'b0, w_rd_data}, {24'b0, exp}, tag);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] t0, ret;
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_en[i] = 0; m_idx[i] = 0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check({31'b0, rd_valid}, 32'd0, "R10 rd_valid in reset");
    check(ts_count, 32'd0, "R10/R8 ts in reset");
    rst = 0;
    for (int i = 0; i < 4; i++) rd(i, 2'd0, 1'b0, 32'd0, "R10 count after reset");
    rd(0, 2'd2, 1'b0, 32'd0, "R10 capture after reset");

    // R2: unconfigured channel does not count
    pulse(0, 3);
    rd(0, 2'd0, 1'b0, m_cnt[0], "R2 unconfigured");

    cfg(0, 1'b1, 8'd7); cfg(0, 1'b0, 8'd1);
    for (int k = 0; k < 3; k++) pulse(0, 3);
    rd(0, 2'd0, 1'b0, m_cnt[0], "R1 three edges");
    rd(0, 2'd0, 1'b0, m_cnt[0], "R4 live read leaves count");
    pulse(0, 25);
    rd(0, 2'd0, 1'b0, m_cnt[0], "R1 long high counts once");

    // R2: wrong index, then enable value other than 1
    cfg(1, 1'b1, 8'd5); cfg(1, 1'b0, 8'd1);
    pulse(1, 3);
    rd(1, 2'd0, 1'b0, 32'd0, "R2 wrong index");
    cfg(1, 1'b1, 8'd7);
    pulse(1, 3); pulse(1, 3);
    rd(1, 2'd0, 1'b0, m_cnt[1], "R2 index 7 counts");
    cfg(1, 1'b0, 8'd3);
    pulse(1, 3);
    rd(1, 2'd0, 1'b0, m_cnt[1], "R2 enable value 3 disables");
    cfg(1, 1'b0, 8'd1);

    // R3: disabled channel holds
    cfg(0, 1'b0, 8'd0);
    pulse(0, 3); pulse(0, 3);
    rd(0, 2'd0, 1'b0, m_cnt[0], "R3 disabled holds");

    // R7: busy gating
    for (int c = 2; c < 4; c++) begin cfg(c, 1'b1, 8'd7); cfg(c, 1'b0, 8'd1); end
    chan_busy = 4'b1110;
    pulse(1, 3); pulse(2, 3); pulse(3, 3);
    rd(1, 2'd0, 1'b0, m_cnt[1], "R7 busy blocks ch1");
    rd(2, 2'd0, 1'b0, m_cnt[2], "R7 ch2 ignores busy");
    rd(3, 2'd0, 1'b0, m_cnt[3], "R7 busy blocks ch3");
    check(m_cnt[2], 32'd1, "R7 model sanity ch2");
    chan_busy = 4'b0000;
    pulse(3, 3);
    rd(3, 2'd0, 1'b0, m_cnt[3], "R7 ch3 after release");

    // R5 read and clear
    rd(1, 2'd1, 1'b0, m_cnt[1], "R5 clear returns count");
    m_cnt[1] = 0;
    rd(1, 2'd0, 1'b0, 32'd0, "R5 zero after clear");
    pulse(1, 3); pulse(1, 3);
    // R5 edge in the same cycle as clear
    @(negedge clk); sig_in[1] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rd_req = 1; rd_chan = 2'd1; rd_kind = 2'd1;
    sb.push_back('{m_cnt[1], "R5 clear with edge returns"});
    @(negedge clk); rd_req = 0;
    repeat (3) @(negedge clk); sig_in[1] = 0;
    repeat (3) @(negedge clk);
    m_cnt[1] = 1;
    rd(1, 2'd0, 1'b0, 32'd1, "R5 edge kept as 1");

    // R6 narrow on main instance, wide read keeps capture
    rd(2, 2'd0, 1'b1, m_cnt[2] & 32'hFFFF, "R6 narrow low half");
    rd(0, 2'd0, 1'b0, m_cnt[0], "R6 wide read");
    rd(0, 2'd2, 1'b0, m_cnt[2] >> 16, "R6 capture after wide read");

    // R8 timestamp pace
    @(negedge clk); t0 = ts_count;
    repeat (10) @(negedge clk);
    check(ts_count - t0, 32'd5, "R8 five steps in ten cycles");

    // R6 and R9 on narrow instance (8-bit count, 4-bit halves)
    w_cfg(1'b1, 8'd7); w_cfg(1'b0, 8'd1);
    for (int k = 0; k < 90; k++) w_pulse();
    w_rd(2'd0, 1'b1, 8'h0A, "R6 split low");
    w_rd(2'd2, 1'b0, 8'h05, "R6 split high");
    w_rd(2'd0, 1'b0, 8'h5A, "R6 wide after split");
    for (int k = 90; k < 255; k++) w_pulse();
    w_rd(2'd0, 1'b0, 8'hFF, "R9 at maximum");
    w_pulse();
    w_rd(2'd0, 1'b0, 8'h00, "R9 wrapped");
    w_pulse();
    w_rd(2'd1, 1'b1, 8'h01, "R5/R6 narrow clear");
    w_rd(2'd0, 1'b0, 8'h00, "R5 narrow clear zeroes");

    repeat (3) @(negedge clk);
    check(sb.size(), 32'd0, "R4 all reads answered");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule